// File: doc/BRIEF.md
# Truncated-Unary plus Exp-Golomb Bin String Generator

This block turns one syntax-element value into the serial bin string an arithmetic entropy coder consumes. The string starts with a truncated-unary run, capped at a cutoff. When the magnitude reaches that cutoff, an Exp-Golomb code of order k carries the excess. The block supports two element kinds. The first is a coefficient level, whose input is the absolute level minus one. The second is a motion-vector difference, which is signed. The kind sets both the cutoff and the starting order k.

The block hands out one bin per cycle over a valid/ready handshake. Each bin carries two flags. The first tells the coder whether the bin is modelled by a context (unary run) or sent at even odds (Exp-Golomb part and sign). The second marks the final bin of the element. A new element is taken only while the block is idle, and it becomes idle again only after the final bin has been consumed.

Top module: `ueg_binarizer`

## Requirements
- R1: After reset the block is idle (`idle_o`=1) and presents no bin (`bin_valid_o`=0).
- R2: A start is accepted only while `idle_o`=1. A start pulse while an element is in flight changes neither the bins of that element nor the bins that follow it.
- R3: The unary run uses a cutoff U of 14 for levels (`mode_i`=0) and 9 for motion-vector differences (`mode_i`=1). A magnitude m below U gives m one-bins followed by a single zero-bin. A magnitude m of at least U gives exactly U one-bins and no zero-bin.
- R4: Unary-run bins carry `bin_bypass_o`=0. Every Exp-Golomb bin and the sign bin carry `bin_bypass_o`=1.
- R5: For m ≥ U, the excess r = m−U is coded with k starting at 0 for levels and 3 for motion-vector differences. The loop is: while r ≥ 2^k, emit 1, subtract 2^k from r, and add one to k. Then emit 0, then emit the k low bits of r, most significant bit first.
- R6: In level mode `value_i` is read as unsigned. In motion-vector mode it is read as two's complement, and m = |value|. A nonzero motion-vector difference ends with one sign bin (1 = negative). A zero difference has no sign bin.
- R7: `bin_last_o` is 1 on the final bin of the element and 0 on every other bin.
- R8: While `bin_valid_o`=1 and `bin_ready_i`=0, the bin and both of its flags hold their values.
- R9: The cycle after the final bin is taken, `idle_o` is 1 and `bin_valid_o` is 0.
- R10: The first bin is valid in the cycle after the start is accepted, and it is a context-coded bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to binarize `value_i` |
| mode_i | input | 1 | 0 = coefficient level, 1 = motion-vector difference |
| value_i | input | VAL_W | Element value (unsigned for levels, signed for differences) |
| idle_o | output | 1 | High when a start would be accepted |
| bin_valid_o | output | 1 | A bin is presented |
| bin_ready_i | input | 1 | The consumer takes the bin this cycle |
| bin_o | output | 1 | Bin value |
| bin_bypass_o | output | 1 | 1 = equiprobable bin, 0 = context-coded bin |
| bin_last_o | output | 1 | Final bin of the element |

## Verification
Every level magnitude from 0 to 2000 is sent, and every motion-vector magnitude over the same range with alternating signs. This covers values below, at, and just past each cutoff, so it separates a terminated unary run from a capped one. It also crosses every power-of-two boundary where the Exp-Golomb order steps up. The largest unsigned level and the most negative difference test the widest suffix and the magnitude of the extreme negative value. For the low values the consumer stalls at random, which tests the hold rule. One element also receives a start pulse in mid-stream, which must not disturb its bin string or the bins that follow.

// File: rtl/ueg_pkg.sv
package ueg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_TU   = 3'd1,
    PH_EGU  = 3'd2,
    PH_EGB  = 3'd3,
    PH_SIGN = 3'd4
  } ueg_phase_e;

  function automatic int unsigned ueg_bits_for(input int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) <= n) b++;
    return b;
  endfunction
endpackage

// File: rtl/ueg_mode_cfg.sv
module ueg_mode_cfg #(
  parameter int unsigned LVL_CUT = 14,
  parameter int unsigned MVD_CUT = 9,
  parameter int unsigned LVL_K   = 0,
  parameter int unsigned MVD_K   = 3,
  parameter int unsigned CW      = 4,
  parameter int unsigned KW      = 5
) (
  input  logic          is_mvd,
  output logic [CW-1:0] cut,
  output logic [KW-1:0] k0
);
  assign cut = is_mvd ? CW'(MVD_CUT) : CW'(LVL_CUT);
  assign k0  = is_mvd ? KW'(MVD_K)   : KW'(LVL_K);
endmodule

// File: rtl/ueg_mag_unit.sv
module ueg_mag_unit #(
  parameter int unsigned VAL_W = 16
) (
  input  logic             is_mvd,
  input  logic [VAL_W-1:0] value,
  output logic [VAL_W-1:0] mag,
  output logic             neg
);
  logic [VAL_W-1:0] flipped;
  assign neg     = is_mvd & value[VAL_W-1];
  assign flipped = ~value + VAL_W'(1);
  assign mag     = neg ? flipped : value;
endmodule

// File: rtl/ueg_bin_fsm.sv
module ueg_bin_fsm
  import ueg_pkg::*;
#(
  parameter int unsigned VAL_W = 16,
  parameter int unsigned CW    = 4,
  parameter int unsigned KW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             ld_mvd,
  input  logic             ld_neg,
  input  logic [VAL_W-1:0] ld_mag,
  input  logic [CW-1:0]    ld_cut,
  input  logic [KW-1:0]    ld_k0,
  input  logic             take,
  output logic             idle,
  output logic             valid,
  output logic             bin,
  output logic             bypass,
  output logic             last
);
  localparam int unsigned VW1 = VAL_W + 1;
  localparam int unsigned IW  = (VAL_W > 1) ? $clog2(VAL_W) : 1;

  ueg_phase_e       ph, nxt_ph;
  logic [VAL_W-1:0] mag, rem;
  logic             is_mvd, neg;
  logic [CW-1:0]    cut, tu_i;
  logic [KW-1:0]    k, bidx;
  logic [VW1-1:0]   step;
  logic             tu_end, over_cut, eg_geq, sign_due;
  ueg_phase_e       tail_ph;

  assign step     = VW1'(1) << k;
  assign over_cut = mag >= VAL_W'(cut);
  assign tu_end   = (VAL_W'(tu_i) == mag) || (tu_i == cut - CW'(1));
  assign eg_geq   = {1'b0, rem} >= step;
  assign sign_due = is_mvd && (mag != '0);
  assign tail_ph  = sign_due ? PH_SIGN : PH_IDLE;

  always_comb begin
    nxt_ph = ph;
    bin    = 1'b0;
    bypass = 1'b1;
    unique case (ph)
      PH_TU: begin
        bin    = VAL_W'(tu_i) < mag;
        bypass = 1'b0;
        if (tu_end) nxt_ph = over_cut ? PH_EGU : tail_ph;
      end
      PH_EGU: begin
        bin = eg_geq;
        if (!eg_geq) nxt_ph = (k == '0) ? tail_ph : PH_EGB;
      end
      PH_EGB: begin
        bin = rem[bidx[IW-1:0]];
        if (bidx == '0) nxt_ph = tail_ph;
      end
      PH_SIGN: begin
        bin    = neg;
        nxt_ph = PH_IDLE;
      end
      default: nxt_ph = PH_IDLE;
    endcase
  end

  assign idle  = (ph == PH_IDLE);
  assign valid = !idle;
  assign last  = valid && (nxt_ph == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      mag    <= '0;
      rem    <= '0;
      is_mvd <= 1'b0;
      neg    <= 1'b0;
      cut    <= '0;
      tu_i   <= '0;
      k      <= '0;
      bidx   <= '0;
    end else if (idle) begin
      if (load) begin
        ph     <= PH_TU;
        mag    <= ld_mag;
        rem    <= ld_mag - VAL_W'(ld_cut);
        is_mvd <= ld_mvd;
        neg    <= ld_neg;
        cut    <= ld_cut;
        tu_i   <= '0;
        k      <= ld_k0;
        bidx   <= '0;
      end
    end else if (take) begin
      ph <= nxt_ph;
      unique case (ph)
        PH_TU:  tu_i <= tu_i + CW'(1);
        PH_EGU: begin
          if (eg_geq) begin
            rem <= rem - step[VAL_W-1:0];
            k   <= k + KW'(1);
          end else begin
            bidx <= k - KW'(1);
          end
        end
        PH_EGB: bidx <= bidx - KW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ueg_binarizer.sv
module ueg_binarizer
  import ueg_pkg::*;
#(
  parameter int unsigned VAL_W   = 16,
  parameter int unsigned LVL_CUT = 14,
  parameter int unsigned MVD_CUT = 9,
  parameter int unsigned LVL_K   = 0,
  parameter int unsigned MVD_K   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [VAL_W-1:0] value_i,
  output logic             idle_o,
  output logic             bin_valid_o,
  input  logic             bin_ready_i,
  output logic             bin_o,
  output logic             bin_bypass_o,
  output logic             bin_last_o
);
  localparam int unsigned MAX_CUT = (LVL_CUT > MVD_CUT) ? LVL_CUT : MVD_CUT;
  localparam int unsigned MAX_K   = (LVL_K > MVD_K) ? LVL_K : MVD_K;
  localparam int unsigned CW      = ueg_bits_for(MAX_CUT);
  localparam int unsigned KW      = ueg_bits_for(VAL_W + MAX_K + 1);

  logic [VAL_W-1:0] in_mag;
  logic             in_neg;
  logic [CW-1:0]    in_cut;
  logic [KW-1:0]    in_k0;
  logic             take;

  assign take = bin_valid_o & bin_ready_i;

  ueg_mag_unit #(.VAL_W(VAL_W)) u_mag (
    .is_mvd (mode_i),
    .value  (value_i),
    .mag    (in_mag),
    .neg    (in_neg)
  );

  ueg_mode_cfg #(
    .LVL_CUT(LVL_CUT), .MVD_CUT(MVD_CUT), .LVL_K(LVL_K), .MVD_K(MVD_K),
    .CW(CW), .KW(KW)
  ) u_cfg (
    .is_mvd (mode_i),
    .cut    (in_cut),
    .k0     (in_k0)
  );

  ueg_bin_fsm #(.VAL_W(VAL_W), .CW(CW), .KW(KW)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start_i),
    .ld_mvd (mode_i),
    .ld_neg (in_neg),
    .ld_mag (in_mag),
    .ld_cut (in_cut),
    .ld_k0  (in_k0),
    .take   (take),
    .idle   (idle_o),
    .valid  (bin_valid_o),
    .bin    (bin_o),
    .bypass (bin_bypass_o),
    .last   (bin_last_o)
  );
endmodule

// File: rtl/ueg_binarizer_chk.sv
module ueg_binarizer_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic idle_o,
  input logic bin_valid_o,
  input logic bin_ready_i,
  input logic bin_o,
  input logic bin_bypass_o,
  input logic bin_last_o
);
  logic fire;
  assign fire = bin_valid_o & bin_ready_i;

  AST_IDLE_NO_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !bin_valid_o); // R1

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_valid_o && !bin_ready_i) |=> (bin_valid_o && $stable(bin_o) && $stable(bin_bypass_o) && $stable(bin_last_o))); // R8

  AST_BYPASS_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bin_bypass_o && !bin_last_o) |=> bin_bypass_o); // R4

  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && bin_last_o) |=> (idle_o && !bin_valid_o)); // R9

  AST_FIRST_BIN_REGULAR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && idle_o) |=> (bin_valid_o && !bin_bypass_o)); // R10

  AST_BUSY_UNTIL_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !bin_last_o) |=> !idle_o); // R2
endmodule

bind ueg_binarizer ueg_binarizer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .idle_o       (idle_o),
  .bin_valid_o  (bin_valid_o),
  .bin_ready_i  (bin_ready_i),
  .bin_o        (bin_o),
  .bin_bypass_o (bin_bypass_o),
  .bin_last_o   (bin_last_o)
);

// File: tb/tb_ueg_binarizer.sv
`timescale 1ns/1ps
module tb_ueg_binarizer;
  localparam int VW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          mode_i = 1'b0;
  logic [VW-1:0] value_i = '0;
  logic          bin_ready_i = 1'b0;
  logic          idle_o, bin_valid_o, bin_o, bin_bypass_o, bin_last_o;

  int total = 0;
  int bad   = 0;
  bit stall_on = 1'b1;
  bit finished = 1'b0;

  logic [2:0] exp_q[$];   // {bin, bypass, last}
  string      tag_q[$];

  always #5 clk = ~clk;

  ueg_binarizer dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .value_i(value_i), .idle_o(idle_o), .bin_valid_o(bin_valid_o),
    .bin_ready_i(bin_ready_i), .bin_o(bin_o), .bin_bypass_o(bin_bypass_o),
    .bin_last_o(bin_last_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // expected bin string, built from the requirements (R3, R5, R6)
  task automatic push_expected(input bit mvd, input int val);
    logic [2:0] items[$];
    string      tags[$];
    int m, u, k, r, base, l, nb;
    bit neg;
    neg = mvd && (val < 0);
    m   = neg ? -val : val;
    u   = mvd ? 9 : 14;
    k   = mvd ? 3 : 0;
    for (int i = 0; i < ((m < u) ? m : u); i++) begin
      items.push_back(3'b100); tags.push_back("R3");
    end
    if (m < u) begin
      items.push_back(3'b000); tags.push_back("R3");
    end else begin
      r = m - u; base = 0; l = 0;
      while (r >= base + (1 << (k + l))) begin
        base += (1 << (k + l));
        l++;
      end
      for (int i = 0; i < l; i++) begin
        items.push_back(3'b110); tags.push_back("R5");
      end
      items.push_back(3'b010); tags.push_back("R5");
      nb = k + l;
      for (int i = nb - 1; i >= 0; i--) begin
        items.push_back({((r - base) >> i) & 1 ? 1'b1 : 1'b0, 2'b10});
        tags.push_back("R5");
      end
    end
    if (mvd && m != 0) begin
      items.push_back({neg, 2'b10}); tags.push_back("R6");
    end
    items[items.size()-1][0] = 1'b1;
    foreach (items[i]) begin
      exp_q.push_back(items[i]);
      tag_q.push_back(tags[i]);
    end
  endtask

  task automatic send(input bit mvd, input int val, input bit intrude);
    push_expected(mvd, val);
    @(negedge clk);
    while (!idle_o) @(negedge clk);
    mode_i  = mvd;
    value_i = VW'(val);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(bin_valid_o === 1'b1, "R10", "first bin valid", int'(bin_valid_o), 1);
    if (intrude) begin
      @(negedge clk);
      if (!idle_o) begin
        mode_i  = 1'b1;
        value_i = VW'(-7);
        start_i = 1'b1;   // R2: must be ignored while busy
        @(negedge clk);
        start_i = 1'b0;
      end
    end
  endtask

  // ready driven just after the active edge
  always @(posedge clk) begin
    #1 bin_ready_i <= stall_on ? (($urandom % 4) != 0) : 1'b1;
  end

  // scoreboard monitor, samples at the falling edge
  logic [2:0] held;
  bit held_pend = 1'b0;
  bit last_pend = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (held_pend) begin
        check({bin_o, bin_bypass_o, bin_last_o} == held && bin_valid_o, "R8",
              "stalled bin changed", int'({bin_valid_o, bin_o, bin_bypass_o, bin_last_o}),
              int'({1'b1, held}));
        held_pend = 1'b0;
      end
      if (last_pend) begin
        check(idle_o && !bin_valid_o, "R9", "idle after last",
              int'({idle_o, bin_valid_o}), 2);
        last_pend = 1'b0;
      end
      if (bin_valid_o && bin_ready_i) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2", "unexpected bin", int'(bin_o), -1);
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bin_last_o != e[0])
            check(1'b0, "R7", "last flag", int'(bin_last_o), int'(e[0]));
          else if (bin_bypass_o != e[1])
            check(1'b0, "R4", "bypass flag", int'(bin_bypass_o), int'(e[1]));
          else
            check(bin_o == e[2], t, "bin value", int'(bin_o), int'(e[2]));
          last_pend = bin_last_o;
        end
      end else if (bin_valid_o) begin
        held = {bin_o, bin_bypass_o, bin_last_o};
        held_pend = 1'b1;
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    #2;
    check(idle_o === 1'b1 && bin_valid_o === 1'b0, "R1", "state in reset",
          int'({idle_o, bin_valid_o}), 2);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(idle_o === 1'b1 && bin_valid_o === 1'b0, "R1", "state after reset",
          int'({idle_o, bin_valid_o}), 2);

    // cutoff boundaries and extremes (R3, R5, R6)
    send(1'b0, 13, 1'b0);
    send(1'b0, 14, 1'b0);
    send(1'b1, 8, 1'b0);
    send(1'b1, -9, 1'b0);
    send(1'b1, 0, 1'b0);
    send(1'b0, 1500, 1'b1);        // R2 mid-stream start
    send(1'b0, 65535, 1'b0);
    send(1'b1, -32768, 1'b0);
    send(1'b1, 32767, 1'b0);

    for (int v = 0; v <= 2000; v++) begin
      if (v == 300) stall_on = 1'b0;
      send(1'b0, v, 1'b0);
    end
    stall_on = 1'b1;
    for (int v = 0; v <= 2000; v++) begin
      if (v == 300) stall_on = 1'b0;
      send(1'b1, (v % 2) ? -v : v, 1'b0);
    end

    @(negedge clk);
    while (!idle_o) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R2", "bins left unproduced", exp_q.size(), 0);
    finish_up();
  end
endmodule